// File: doc/BRIEF.md
# Integer Out-of-Order Issue Queue

This block sits between the dispatch stage and the integer reservation stations. It is a six-entry queue filled strictly in program order. Each cycle it can take in up to three dispatched instructions, each tagged with the kind of unit that must run it: load/store, complex integer (multiply-like), or simple integer. It reports back how many dispatch lanes it can take this cycle.

Only the three oldest entries are candidates for issue. In each cycle at most one instruction per unit kind leaves the queue, and the oldest candidate of a kind wins. A younger instruction may leave ahead of an older one whose unit kind has no free reservation-station slot. Free slots are counted per kind with credit counters. A credit comes back when the downstream unit reports that one of its instructions began execution, and that credit can be spent on an issue in the same cycle. Operand readiness plays no part, because instructions wait in the stations for forwarded values. After issue the survivors slide down with no gaps and keep their order. A flush empties the queue and refills every credit.

Top module: `int_issue_queue`

## Requirements
- R1: The queue holds at most DEPTH (default 6) entries. `disp_room` equals min(LANES, DEPTH − occupancy + issues this cycle), so a full queue with nothing issuing reports 0, and lanes beyond `disp_room` are not written.
- R2: Valid dispatch lanes are contiguous from lane 0, and lane 0 is the oldest. Up to LANES (default 3) are written per cycle. A written entry is first eligible for issue in the following cycle.
- R3: Only the WIN (default 3) oldest entries may issue. An entry at position 3 or above never issues, even when its unit kind has free slots.
- R4: Class codes are 0 = load/store, 1 = complex, 2 = simple. `iss_valid` and `exec_start` bit c and `iss_tag` slice c belong to class c. At most one instruction per class issues per cycle, and it is the oldest eligible one of that class.
- R5: An eligible entry whose class has no free slot does not stop younger eligible entries of other classes from issuing in the same cycle.
- R6: Slot counts are LS_SLOTS (default 1) for load/store, CX_SLOTS (2) for complex and SX_SLOTS (3) for simple. Each issue uses one slot and each `exec_start` pulse frees one. A class with no free slot does not issue.
- R7: A slot freed by `exec_start` in a cycle may be used by an issue of that class in the same cycle.
- R8: After issue, the remaining entries keep program order with no holes, so issue order within a class matches dispatch order.
- R9: While `flush` is high nothing issues and `disp_room` is 0. In the next cycle the queue is empty and every class has its full slot count.
- R10: After a synchronous active-low reset the queue is empty, all credits are full, nothing issues and `disp_room` equals LANES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the queue and refill all credits |
| disp_valid | input | LANES | Dispatch lane valid, contiguous from lane 0 |
| disp_cls | input | 2*LANES | Class code per lane (lane k at bits 2k+1:2k) |
| disp_tag | input | TAG_W*LANES | Instruction tag per lane |
| disp_room | output | $clog2(LANES+1) | Number of lanes accepted this cycle |
| exec_start | input | 3 | Per class: one station entry began execution |
| iss_valid | output | 3 | Per class: an instruction issues this cycle |
| iss_tag | output | 3*TAG_W | Per class: tag of the issued instruction |

## Verification
The assertions assume a well-behaved environment. Dispatch lanes are contiguous from lane 0 and carry only class codes 0 to 2. `exec_start` pulses for a class only while at least one of its slots is in use, so a credit counter never goes above its slot count. The stimulus respects both rules: every return is placed after an issue of that class has left a slot occupied, and the bench counts slots per class when it picks return cycles, including the returns that refill the counters after the first scenario.

// File: rtl/iq_pkg.sv
// Shared definitions for the integer issue queue.
// Assumes exactly three unit classes; the code values are visible on ports.
package iq_pkg;
    localparam int NUM_CLS = 3;
    localparam int CLS_W   = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_LS = 2'd0,
        CLS_CX = 2'd1,
        CLS_SX = 2'd2
    } uclass_e;
endpackage

// File: rtl/iq_credit.sv
// Free reservation-station slot counter for one unit class.
// Assumes 'give' only arrives while at least one slot is in use, and that
// 'take' is raised only when 'avail' is high. A give and a take in the
// same cycle cancel, which lets a freed slot be reused at once.
module iq_credit #(
    parameter int MAX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic take,
    input  logic give,
    output logic avail
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] credit;

    // A slot exists now, or one is freed in this very cycle.
    assign avail = (credit != '0) || give;

    // Counter update: reset and flush refill, otherwise net of take and give.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            credit <= CW'(MAX);
        end else if (take && !give) begin
            credit <= credit - 1'b1;
        end else if (give && !take) begin
            credit <= credit + 1'b1;
        end
    end

    assert_credit_bound_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CW'(MAX));

    assert_return_in_use_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        give |-> credit < CW'(MAX));

    assert_take_needs_slot_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (credit != '0 || give));
endmodule

// File: rtl/iq_pick.sv
// Issue selector over the bottom window of the queue.
// For each class, grants the oldest valid window entry of that class if the
// class may issue. The classes are chosen independently, so a blocked class
// does not stall the others. Assumes window entry 0 is the oldest.
module iq_pick #(
    parameter int WIN     = 3,
    parameter int NUM_CLS = 3,
    parameter int CLS_W   = 2
) (
    input  logic [WIN-1:0]         win_valid,
    input  logic [CLS_W-1:0]       win_cls  [WIN],
    input  logic [NUM_CLS-1:0]     cls_ok,
    output logic [WIN-1:0]         grant,
    output logic [NUM_CLS-1:0]     cls_take,
    output logic [$clog2(WIN)-1:0] cls_src  [NUM_CLS]
);
    localparam int WIN_W = $clog2(WIN);

    logic [WIN-1:0] gmat [NUM_CLS];

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        logic             take_c;
        logic [WIN_W-1:0] src_c;

        // Oldest-first scan of the window for this class.
        always_comb begin
            logic found;
            found   = 1'b0;
            gmat[c] = '0;
            take_c  = 1'b0;
            src_c   = '0;
            for (int i = 0; i < WIN; i++) begin
                if (!found && win_valid[i] && cls_ok[c] &&
                    win_cls[i] == CLS_W'(c)) begin
                    found      = 1'b1;
                    gmat[c][i] = 1'b1;
                    take_c     = 1'b1;
                    src_c      = WIN_W'(i);
                end
            end
        end

        assign cls_take[c] = take_c;
        assign cls_src[c]  = src_c;

        assert_one_per_class_R4 : assert final ($onehot0(gmat[c]));
    end

    // Merge the per-class grants into one issued-entry mask.
    always_comb begin
        grant = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            grant = grant | gmat[c];
        end
    end

    assert_grant_valid_R3 : assert final ((grant & ~win_valid) == '0);
endmodule

// File: rtl/iq_store.sv
// Entry storage with compaction for the issue queue.
// Each cycle it drops the issued window entries, slides the survivors down
// in order, then appends the accepted dispatch lanes above them. Assumes the
// caller accepts no more lanes than there are free entries after issue.
module iq_store #(
    parameter int DEPTH = 6,
    parameter int LANES = 3,
    parameter int WIN   = 3,
    parameter int TAG_W = 6,
    parameter int CLS_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [WIN-1:0]               issued,
    input  logic [$clog2(LANES+1)-1:0]   n_acc,
    input  logic [LANES*CLS_W-1:0]       lane_cls,
    input  logic [LANES*TAG_W-1:0]       lane_tag,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [WIN-1:0]               win_valid,
    output logic [CLS_W-1:0]             win_cls [WIN],
    output logic [TAG_W-1:0]             win_tag [WIN]
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ACC_W = $clog2(LANES + 1);

    logic [CLS_W-1:0] q_cls [DEPTH];
    logic [TAG_W-1:0] q_tag [DEPTH];
    logic [CLS_W-1:0] n_cls [DEPTH];
    logic [TAG_W-1:0] n_tag [DEPTH];
    logic [CNT_W-1:0] n_count;

    // Compact the survivors, then append the accepted lanes in lane order.
    always_comb begin
        logic [CNT_W-1:0] idx;
        logic             keep;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            n_cls[i] = q_cls[i];
            n_tag[i] = q_tag[i];
        end
        for (int i = 0; i < DEPTH; i++) begin
            keep = (CNT_W'(i) < count);
            if (i < WIN) begin
                keep = keep && !issued[i];
            end
            if (keep) begin
                n_cls[idx] = q_cls[i];
                n_tag[idx] = q_tag[i];
                idx        = idx + 1'b1;
            end
        end
        for (int k = 0; k < LANES; k++) begin
            if (ACC_W'(k) < n_acc) begin
                n_cls[idx] = lane_cls[k*CLS_W +: CLS_W];
                n_tag[idx] = lane_tag[k*TAG_W +: TAG_W];
                idx        = idx + 1'b1;
            end
        end
        n_count = idx;
    end

    // Register the compacted contents; reset and flush empty the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                q_cls[i] <= '0;
                q_tag[i] <= '0;
            end
        end else begin
            count <= n_count;
            for (int i = 0; i < DEPTH; i++) begin
                q_cls[i] <= n_cls[i];
                q_tag[i] <= n_tag[i];
            end
        end
    end

    // Present the bottom window to the selector.
    always_comb begin
        for (int i = 0; i < WIN; i++) begin
            win_valid[i] = (CNT_W'(i) < count);
            win_cls[i]   = q_cls[i];
            win_tag[i]   = q_tag[i];
        end
    end

    assert_no_overflow_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_flush_empties_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
endmodule

// File: rtl/int_issue_queue.sv
// Top of the integer issue queue.
// Joins the entry store, the bottom-window selector and one credit counter
// per unit class, and works out how many dispatch lanes fit this cycle.
// Assumes valid dispatch lanes are contiguous from lane 0, that class codes
// are 0..2, and that exec_start pulses only for classes holding a slot.
module int_issue_queue #(
    parameter int DEPTH    = 6,
    parameter int LANES    = 3,
    parameter int WIN      = 3,
    parameter int TAG_W    = 6,
    parameter int LS_SLOTS = 1,
    parameter int CX_SLOTS = 2,
    parameter int SX_SLOTS = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                flush,
    input  logic [LANES-1:0]                    disp_valid,
    input  logic [LANES*iq_pkg::CLS_W-1:0]      disp_cls,
    input  logic [LANES*TAG_W-1:0]              disp_tag,
    output logic [$clog2(LANES+1)-1:0]          disp_room,
    input  logic [iq_pkg::NUM_CLS-1:0]          exec_start,
    output logic [iq_pkg::NUM_CLS-1:0]          iss_valid,
    output logic [iq_pkg::NUM_CLS*TAG_W-1:0]    iss_tag
);
    import iq_pkg::*;

    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int ACC_W  = $clog2(LANES + 1);
    localparam int FREE_W = CNT_W + 1;
    localparam int WIN_W  = $clog2(WIN);

    logic [CNT_W-1:0]   count;
    logic [WIN-1:0]     win_valid;
    logic [CLS_W-1:0]   win_cls [WIN];
    logic [TAG_W-1:0]   win_tag [WIN];
    logic [WIN-1:0]     grant;
    logic [NUM_CLS-1:0] cls_take;
    logic [WIN_W-1:0]   cls_src [NUM_CLS];
    logic [NUM_CLS-1:0] cls_avail;
    logic [NUM_CLS-1:0] cls_ok;
    logic [CNT_W-1:0]   n_issue;
    logic [ACC_W-1:0]   n_acc;
    logic [FREE_W-1:0]  free_after;

    iq_store #(
        .DEPTH(DEPTH), .LANES(LANES), .WIN(WIN), .TAG_W(TAG_W), .CLS_W(CLS_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .issued   (grant),
        .n_acc    (n_acc),
        .lane_cls (disp_cls),
        .lane_tag (disp_tag),
        .count    (count),
        .win_valid(win_valid),
        .win_cls  (win_cls),
        .win_tag  (win_tag)
    );

    // Nothing issues while a flush is in progress.
    assign cls_ok = cls_avail & {NUM_CLS{!flush}};

    iq_pick #(
        .WIN(WIN), .NUM_CLS(NUM_CLS), .CLS_W(CLS_W)
    ) u_pick (
        .win_valid(win_valid),
        .win_cls  (win_cls),
        .cls_ok   (cls_ok),
        .grant    (grant),
        .cls_take (cls_take),
        .cls_src  (cls_src)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_credit
        localparam int SLOTS = (c == int'(CLS_LS)) ? LS_SLOTS :
                               (c == int'(CLS_CX)) ? CX_SLOTS : SX_SLOTS;
        iq_credit #(.MAX(SLOTS)) u_credit (
            .clk  (clk),
            .rst_n(rst_n),
            .flush(flush),
            .take (cls_take[c]),
            .give (exec_start[c]),
            .avail(cls_avail[c])
        );
        assign iss_valid[c]               = cls_take[c];
        assign iss_tag[c*TAG_W +: TAG_W]  = win_tag[cls_src[c]];
    end

    // Count the entries leaving the queue this cycle.
    always_comb begin
        n_issue = '0;
        for (int i = 0; i < WIN; i++) begin
            n_issue = n_issue + CNT_W'(grant[i]);
        end
    end

    // Lanes that fit: free space after issue, capped at the lane count.
    always_comb begin
        free_after = FREE_W'(DEPTH) - FREE_W'(count) + FREE_W'(n_issue);
        if (flush) begin
            disp_room = '0;
        end else if (free_after >= FREE_W'(LANES)) begin
            disp_room = ACC_W'(LANES);
        end else begin
            disp_room = ACC_W'(free_after);
        end
    end

    // Count the valid lanes that fall inside the accepted room.
    always_comb begin
        n_acc = '0;
        for (int k = 0; k < LANES; k++) begin
            if (disp_valid[k] && ACC_W'(k) < disp_room) begin
                n_acc = n_acc + 1'b1;
            end
        end
    end

    assert_count_track_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> count == $past(count) - $past(n_issue) + CNT_W'($past(n_acc)));

    assert_issue_within_occupancy_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'($countones(iss_valid)) <= count);

    assert_flush_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (iss_valid == '0 && disp_room == '0));

    assert_empty_no_issue_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        count == '0 |-> iss_valid == '0);
endmodule

// File: tb/int_issue_queue_tb.sv
module int_issue_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [2:0]  disp_valid = '0;
    logic [5:0]  disp_cls = '0;
    logic [17:0] disp_tag = '0;
    logic [1:0]  disp_room;
    logic [2:0]  exec_start = '0;
    logic [2:0]  iss_valid;
    logic [17:0] iss_tag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_issue_queue u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_cls(disp_cls), .disp_tag(disp_tag),
        .disp_room(disp_room), .exec_start(exec_start),
        .iss_valid(iss_valid), .iss_tag(iss_tag)
    );

    // Row: lanes, classes {l2,l1,l0}, tags {l2,l1,l0}, returns, expected
    // issue mask, expected tags {sx,cx,ls}, expected room, requirement code.
    typedef struct packed {
        logic [2:0]  dv;
        logic [5:0]  cls;
        logic [17:0] tag;
        logic [2:0]  ret;
        logic [2:0]  eiv;
        logic [17:0] etag;
        logic [1:0]  eroom;
        logic [3:0]  req;
    } row_t;

    localparam row_t VEC [NROWS] = '{
        // R2: three complex ops enter an empty queue
        '{3'b111, {2'd1,2'd1,2'd1}, {6'd2,6'd1,6'd0}, 3'b000, 3'b000, {6'd0,6'd0,6'd0}, 2'd3, 4'd2},
        // R4: oldest complex (t0) wins over t1, t2
        '{3'b111, {2'd2,2'd2,2'd0}, {6'd5,6'd4,6'd3}, 3'b000, 3'b010, {6'd0,6'd0,6'd0}, 2'd3, 4'd4},
        // R3: simple t4 sits at position 3 and must not issue
        '{3'b011, {2'd0,2'd2,2'd2}, {6'd0,6'd7,6'd6}, 3'b000, 3'b011, {6'd0,6'd1,6'd3}, 2'd3, 4'd3},
        // R5: complex t2 blocked at bottom, simple t4 bypasses it
        '{3'b000, 6'd0, 18'd0, 3'b000, 3'b100, {6'd4,6'd0,6'd0}, 2'd2, 4'd5},
        // R8: simple ops leave in dispatch order
        '{3'b000, 6'd0, 18'd0, 3'b000, 3'b100, {6'd5,6'd0,6'd0}, 2'd3, 4'd8},
        // R7: complex slot freed and reused in the same cycle
        '{3'b000, 6'd0, 18'd0, 3'b010, 3'b110, {6'd6,6'd2,6'd0}, 2'd3, 4'd7},
        // R6: simple slots exhausted, t7 waits
        '{3'b000, 6'd0, 18'd0, 3'b000, 3'b000, {6'd0,6'd0,6'd0}, 2'd3, 4'd6},
        // R7: simple slot freed and reused at once
        '{3'b000, 6'd0, 18'd0, 3'b100, 3'b100, {6'd7,6'd0,6'd0}, 2'd3, 4'd7},
        // R6: refill credits
        '{3'b000, 6'd0, 18'd0, 3'b111, 3'b000, {6'd0,6'd0,6'd0}, 2'd3, 4'd6},
        '{3'b000, 6'd0, 18'd0, 3'b010, 3'b000, {6'd0,6'd0,6'd0}, 2'd3, 4'd6},
        '{3'b000, 6'd0, 18'd0, 3'b100, 3'b000, {6'd0,6'd0,6'd0}, 2'd3, 4'd6},
        '{3'b000, 6'd0, 18'd0, 3'b100, 3'b000, {6'd0,6'd0,6'd0}, 2'd3, 4'd6},
        // R2: three loads
        '{3'b111, {2'd0,2'd0,2'd0}, {6'd10,6'd9,6'd8}, 3'b000, 3'b000, {6'd0,6'd0,6'd0}, 2'd3, 4'd2},
        // R4: one load per cycle, oldest first
        '{3'b111, {2'd0,2'd0,2'd0}, {6'd13,6'd12,6'd11}, 3'b000, 3'b001, {6'd0,6'd0,6'd8}, 2'd3, 4'd4},
        // R1: only one lane fits
        '{3'b111, {2'd0,2'd0,2'd0}, {6'd16,6'd15,6'd14}, 3'b000, 3'b000, {6'd0,6'd0,6'd0}, 2'd1, 4'd1},
        // R1: full queue accepts nothing
        '{3'b001, {2'd2,2'd2,2'd2}, {6'd0,6'd0,6'd20}, 3'b000, 3'b000, {6'd0,6'd0,6'd0}, 2'd0, 4'd1},
        // R7: load slot returns and is reused
        '{3'b000, 6'd0, 18'd0, 3'b001, 3'b001, {6'd0,6'd0,6'd9}, 2'd1, 4'd7}
    };

    function automatic string req_name(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare outputs of the current cycle with expectations.
    task automatic check_out(input string req, input logic [2:0] eiv,
                             input logic [17:0] etag, input logic [1:0] eroom);
        check(req, "iss_valid", int'(iss_valid), int'(eiv));
        check(req, "disp_room", int'(disp_room), int'(eroom));
        for (int c = 0; c < 3; c++) begin
            if (eiv[c]) begin
                check(req, $sformatf("iss_tag class %0d", c),
                      int'(iss_tag[c*6 +: 6]), int'(etag[c*6 +: 6]));
            end
        end
    endtask

    // Drive one cycle of inputs at the falling edge, check, then wait for the rise.
    task automatic step(input logic fl, input logic [2:0] dv, input logic [5:0] cl,
                        input logic [17:0] tg, input logic [2:0] rt,
                        input logic [2:0] eiv, input logic [17:0] etag,
                        input logic [1:0] eroom, input string req);
        @(negedge clk);
        flush = fl; disp_valid = dv; disp_cls = cl; disp_tag = tg; exec_start = rt;
        #1;
        check_out(req, eiv, etag, eroom);
        @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: empty after reset, full room, nothing issued
        check_out("R10", 3'b000, 18'd0, 2'd3);

        for (int r = 0; r < NROWS; r++) begin
            step(1'b0, VEC[r].dv, VEC[r].cls, VEC[r].tag, VEC[r].ret,
                 VEC[r].eiv, VEC[r].etag, VEC[r].eroom, req_name(int'(VEC[r].req)));
        end

        // R9: flush with a load slot returning; no issue, no room
        step(1'b1, 3'b000, 6'd0, 18'd0, 3'b001, 3'b000, 18'd0, 2'd0, "R9");
        // R9: queue empty after flush; dispatch a load and a complex op
        step(1'b0, 3'b011, {2'd0,2'd1,2'd0}, {6'd0,6'd31,6'd30}, 3'b000,
             3'b000, 18'd0, 2'd3, "R9");
        // R9: credits were refilled, both issue
        step(1'b0, 3'b000, 6'd0, 18'd0, 3'b000,
             3'b011, {6'd0,6'd31,6'd30}, 2'd3, "R9");

        // R10: reset in the middle of a run empties the queue
        step(1'b0, 3'b001, {2'd0,2'd0,2'd1}, {6'd0,6'd0,6'd40}, 3'b000,
             3'b000, 18'd0, 2'd3, "R10");
        @(negedge clk);
        rst_n = 1'b0; disp_valid = '0; exec_start = '0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_out("R10", 3'b000, 18'd0, 2'd3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule